// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the type-0 configuration header of a simple PCI target. When the address phase is flagged, it captures the bus command from the command/byte-enable nibble. It also captures the header offset from the low byte of the registered address. A configuration-read command makes the block present the addressed header dword on its read-data output. A configuration-write command lets each data-phase handshake update the addressed register, one byte lane at a time.

Three fields can be written. The first is the 16-bit Command field at offset 04h. The second is one 32-bit memory Base Address Register at offset 10h, which decodes a 4 KB window. The third is the Interrupt Line byte at offset 3Ch. The identification, status, interrupt-pin and latency fields are constants set by parameters. The surrounding bus logic decodes the device select, drives AD, handles parity and turns the bus around. It also feeds this block the registered IRDY# and TRDY#.

Top module: `pci_cfg_header`

## Requirements
- R1: While reset is active and after it is released, the Command field, the BAR and Interrupt Line read zero, and the read-data output is zero.
- R2: A command nibble captured in the address phase counts only as 1010 (configuration read) or 1011 (configuration write). Any other code makes the read data zero and blocks every register update until the next address phase. A configuration read never updates a register.
- R3: A register updates only on a clock edge where a configuration write is active and both irdy_reg_n_i and trdy_n_i are 0. If either is 1, all registers hold.
- R4: In the data phase, cbe_n_i bit k is an active-low enable for data byte k (bits 8k+7:8k). A lane whose enable is 1 keeps its old value.
- R5: Offset 04h reads Status (a constant) in bits 31:16 and Command in bits 15:0. A write there updates only Command, through byte lanes 0 and 1.
- R6: The BAR at offset 10h is writable in all four lanes. Its bits 11:0 always read zero whatever is written.
- R7: Offset 3Ch reads, from the high byte down: Max_Lat, Min_Gnt, Int_Pin and Int_Line. Only Int_Line (lane 0) is writable.
- R8: Offset 00h reads Device ID in bits 31:16 and Vendor ID in bits 15:0. Offset 08h reads Class Code in bits 31:8 and Revision ID in bits 7:0.
- R9: Writes to any offset other than 04h, 10h and 3Ch are discarded. Reads of unimplemented offsets, including 0Ch and 40h to FFh, return zero.
- R10: Address bits 31:8 are ignored. Bits 7:0 must match the offset exactly, so a nonzero value in bits 1:0 selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_phase_i | input | 1 | High for the cycle that carries the address and the command |
| addr_reg_i | input | 32 | Registered address; bits 7:0 give the header offset |
| cbe_n_i | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| irdy_reg_n_i | input | 1 | Registered initiator-ready, active low |
| trdy_n_i | input | 1 | Target-ready, active low |
| wdata_i | input | 32 | Write data in the data phase |
| rd_data_o | output | 32 | Header dword for the captured offset during a configuration read, zero otherwise |
| cmd_reg_o | output | 16 | Command field contents |
| bar0_o | output | 32 | Base Address Register contents |
| int_line_o | output | 8 | Interrupt Line contents |

## Verification
The command and offset are captured on the clock edge that ends the address phase. rd_data_o is a combinational function of that captured state, so it is due in the very next cycle. A write lands on the edge that sees the handshake, so the register outputs change one cycle after the handshake inputs are driven. The bench drives every input on the falling edge and samples on the falling edge after the edge in question. A check therefore always reads a value settled half a period earlier. Reads that confirm a write begin with a new address phase, so the readback also covers the capture path.

// File: rtl/pci_cfg_hdr_pkg.sv
package pci_cfg_hdr_pkg;

  localparam int DW      = 32;
  localparam int AW      = 32;
  localparam int OFS_W   = 8;
  localparam int LANES   = DW / 8;
  localparam int CMD_W   = 16;
  localparam int CMD_LN  = CMD_W / 8;

  localparam logic [3:0] CODE_CFG_RD = 4'b1010;
  localparam logic [3:0] CODE_CFG_WR = 4'b1011;

  localparam logic [OFS_W-1:0] OFS_IDENT = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_CLASS = 8'h08;
  localparam logic [OFS_W-1:0] OFS_BASE0 = 8'h10;
  localparam logic [OFS_W-1:0] OFS_IRQ   = 8'h3C;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2
  } xfer_e;

  typedef struct packed {
    logic ctrl;
    logic base0;
    logic irq;
  } wr_hit_t;

endpackage

// File: rtl/cfg_phase_capture.sv
module cfg_phase_capture
  import pci_cfg_hdr_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int SEL_W  = OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        code_i,
  output xfer_e             xfer_o,
  output logic [SEL_W-1:0]  ofs_o
);

  xfer_e             xfer_q, xfer_d;
  logic [SEL_W-1:0]  ofs_q, ofs_d;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^addr_i[ADDR_W-1:SEL_W];

  always_comb begin
    xfer_d = xfer_q;
    ofs_d  = ofs_q;
    if (addr_phase_i) begin
      ofs_d = addr_i[SEL_W-1:0];
      unique case (code_i)
        CODE_CFG_RD: xfer_d = XF_READ;
        CODE_CFG_WR: xfer_d = XF_WRITE;
        default:     xfer_d = XF_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= XF_IDLE;
      ofs_q  <= '0;
    end else if (addr_phase_i) begin
      xfer_q <= xfer_d;
      ofs_q  <= ofs_d;
    end
  end

  assign xfer_o = xfer_q;
  assign ofs_o  = ofs_q;

  // R2
  foreign_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase_i && (code_i != CODE_CFG_RD) && (code_i != CODE_CFG_WR))
      |=> (xfer_q == XF_IDLE));

endmodule

// File: rtl/cfg_write_decode.sv
module cfg_write_decode
  import pci_cfg_hdr_pkg::*;
#(
  parameter int SEL_W = OFS_W
) (
  input  xfer_e            xfer_i,
  input  logic [SEL_W-1:0] ofs_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  output wr_hit_t          hit_o
);

  logic beat;

  assign beat = (xfer_i == XF_WRITE) && !irdy_n_i && !trdy_n_i;

  always_comb begin
    hit_o       = '0;
    hit_o.ctrl  = beat && (ofs_i == OFS_CTRL);
    hit_o.base0 = beat && (ofs_i == OFS_BASE0);
    hit_o.irq   = beat && (ofs_i == OFS_IRQ);
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import pci_cfg_hdr_pkg::*;
#(
  parameter int DATA_W   = DW,
  parameter int CTRL_W   = CMD_W,
  parameter int WIN_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_hit_t           hit_i,
  input  logic [DATA_W/8-1:0] be_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] base0_o,
  output logic [7:0]        irq_line_o
);

  localparam int NLANE  = DATA_W / 8;
  localparam int CLANE  = CTRL_W / 8;
  localparam logic [DATA_W-1:0] WIN_MASK = {DATA_W{1'b1}} << WIN_LOG2;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] base_q, base_m, base_d;
  logic [7:0]        irq_q, irq_d;
  logic              ctrl_en, base_en, irq_en;

  assign ctrl_en = hit_i.ctrl;
  assign base_en = hit_i.base0;
  assign irq_en  = hit_i.irq;

  for (genvar ln = 0; ln < CLANE; ln++) begin : g_ctrl_lane
    assign ctrl_d[8*ln +: 8] = be_n_i[ln] ? ctrl_q[8*ln +: 8] : wdata_i[8*ln +: 8];
  end

  for (genvar ln = 0; ln < NLANE; ln++) begin : g_base_lane
    assign base_m[8*ln +: 8] = be_n_i[ln] ? base_q[8*ln +: 8] : wdata_i[8*ln +: 8];
  end

  assign base_d = base_m & WIN_MASK;
  assign irq_d  = be_n_i[0] ? irq_q : wdata_i[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign base0_o    = base_q;
  assign irq_line_o = irq_q;

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i.ctrl |=> $stable(ctrl_q));

  // R4
  base_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i.base0 && be_n_i[NLANE-1]) |=> $stable(base_q[DATA_W-1 -: 8]));

  // R6
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[WIN_LOG2-1:0] == '0);

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import pci_cfg_hdr_pkg::*;
#(
  parameter int          SEL_W     = OFS_W,
  parameter logic [15:0] VEN_ID    = 16'h1A2B,
  parameter logic [15:0] DEV_ID    = 16'h3C4D,
  parameter logic [23:0] CLASS_C   = 24'h118000,
  parameter logic [7:0]  REV_ID    = 8'h01,
  parameter logic [15:0] STAT_VAL  = 16'h0200,
  parameter logic [7:0]  IRQ_PIN   = 8'h01,
  parameter logic [7:0]  GNT_MIN   = 8'h04,
  parameter logic [7:0]  LAT_MAX   = 8'h08
) (
  input  xfer_e            xfer_i,
  input  logic [SEL_W-1:0] ofs_i,
  input  logic [CMD_W-1:0] ctrl_i,
  input  logic [DW-1:0]    base0_i,
  input  logic [7:0]       irq_line_i,
  output logic [DW-1:0]    rd_data_o
);

  logic [DW-1:0] word;

  always_comb begin
    unique case (ofs_i)
      OFS_IDENT: word = {DEV_ID, VEN_ID};
      OFS_CTRL:  word = {STAT_VAL, ctrl_i};
      OFS_CLASS: word = {CLASS_C, REV_ID};
      OFS_BASE0: word = base0_i;
      OFS_IRQ:   word = {LAT_MAX, GNT_MIN, IRQ_PIN, irq_line_i};
      default:   word = '0;
    endcase
  end

  assign rd_data_o = (xfer_i == XF_READ) ? word : '0;

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pci_cfg_hdr_pkg::*;
#(
  parameter int          WIN_LOG2 = 12,
  parameter logic [15:0] VEN_ID   = 16'h1A2B,
  parameter logic [15:0] DEV_ID   = 16'h3C4D,
  parameter logic [23:0] CLASS_C  = 24'h118000,
  parameter logic [7:0]  REV_ID   = 8'h01,
  parameter logic [15:0] STAT_VAL = 16'h0200,
  parameter logic [7:0]  IRQ_PIN  = 8'h01,
  parameter logic [7:0]  GNT_MIN  = 8'h04,
  parameter logic [7:0]  LAT_MAX  = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_phase_i,
  input  logic [AW-1:0] addr_reg_i,
  input  logic [3:0]    cbe_n_i,
  input  logic          irdy_reg_n_i,
  input  logic          trdy_n_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic [15:0]   cmd_reg_o,
  output logic [DW-1:0] bar0_o,
  output logic [7:0]    int_line_o
);

  xfer_e            xfer;
  logic [OFS_W-1:0] ofs;
  wr_hit_t          hit;

  cfg_phase_capture #(.ADDR_W(AW), .SEL_W(OFS_W)) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_phase_i (addr_phase_i),
    .addr_i       (addr_reg_i),
    .code_i       (cbe_n_i),
    .xfer_o       (xfer),
    .ofs_o        (ofs)
  );

  cfg_write_decode #(.SEL_W(OFS_W)) u_wdec (
    .xfer_i   (xfer),
    .ofs_i    (ofs),
    .irdy_n_i (irdy_reg_n_i),
    .trdy_n_i (trdy_n_i),
    .hit_o    (hit)
  );

  cfg_reg_bank #(.DATA_W(DW), .CTRL_W(CMD_W), .WIN_LOG2(WIN_LOG2)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .be_n_i     (cbe_n_i),
    .wdata_i    (wdata_i),
    .ctrl_o     (cmd_reg_o),
    .base0_o    (bar0_o),
    .irq_line_o (int_line_o)
  );

  cfg_read_mux #(
    .SEL_W(OFS_W), .VEN_ID(VEN_ID), .DEV_ID(DEV_ID), .CLASS_C(CLASS_C),
    .REV_ID(REV_ID), .STAT_VAL(STAT_VAL), .IRQ_PIN(IRQ_PIN),
    .GNT_MIN(GNT_MIN), .LAT_MAX(LAT_MAX)
  ) u_rmux (
    .xfer_i     (xfer),
    .ofs_i      (ofs),
    .ctrl_i     (cmd_reg_o),
    .base0_i    (bar0_o),
    .irq_line_i (int_line_o),
    .rd_data_o  (rd_data_o)
  );

  // R3
  no_handshake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_reg_n_i || trdy_n_i)
      |=> ($stable(cmd_reg_o) && $stable(bar0_o) && $stable(int_line_o)));

  // R9
  discard_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((xfer == XF_WRITE) && (ofs != OFS_CTRL) && (ofs != OFS_BASE0) && (ofs != OFS_IRQ))
      |=> ($stable(cmd_reg_o) && $stable(bar0_o) && $stable(int_line_o)));

  // R2
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer != XF_READ) |-> (rd_data_o == '0));

endmodule

// File: tb/test_pci_cfg_header.sv
module test_pci_cfg_header;

  localparam logic [31:0] W_IDENT = 32'h3C4D_1A2B;
  localparam logic [31:0] W_CLASS = 32'h1180_0001;
  localparam logic [15:0] STATUS  = 16'h0200;
  localparam logic [23:0] W_IRQHI = 24'h08_04_01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_phase;
  logic [31:0] addr;
  logic [3:0]  cbe_n;
  logic        irdy_n, trdy_n;
  logic [31:0] wdata;
  logic [31:0] rd_data;
  logic [15:0] cmd_reg;
  logic [31:0] bar0;
  logic [7:0]  int_line;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pci_cfg_header i_pci_cfg_header (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_phase_i (addr_phase),
    .addr_reg_i   (addr),
    .cbe_n_i      (cbe_n),
    .irdy_reg_n_i (irdy_n),
    .trdy_n_i     (trdy_n),
    .wdata_i      (wdata),
    .rd_data_o    (rd_data),
    .cmd_reg_o    (cmd_reg),
    .bar0_o       (bar0),
    .int_line_o   (int_line)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // address phase: drive at falling edge, captured at the next rising edge
  task automatic addr_cycle(input logic [3:0] code, input logic [31:0] a);
    @(negedge clk);
    addr_phase = 1'b1; cbe_n = code; addr = a; irdy_n = 1'b1; trdy_n = 1'b1;
    @(negedge clk);
    addr_phase = 1'b0; cbe_n = 4'hF;
  endtask

  // one data beat; result visible at the falling edge where the task returns
  task automatic data_beat(input logic [31:0] d, input logic [3:0] be_n,
                           input logic ir_n, input logic tr_n);
    cbe_n = be_n; wdata = d; irdy_n = ir_n; trdy_n = tr_n;
    @(negedge clk);
    irdy_n = 1'b1; trdy_n = 1'b1; cbe_n = 4'hF;
  endtask

  task automatic cfg_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be_n);
    addr_cycle(4'b1011, a);
    data_beat(d, be_n, 1'b0, 1'b0);
  endtask

  task automatic cfg_read_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    addr_cycle(4'b1010, a);
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    check("R1 cmd", {16'h0, cmd_reg}, 32'h0);
    check("R1 bar", bar0, 32'h0);
    check("R1 intline", {24'h0, int_line}, 32'h0);
    check("R1 rdata", rd_data, 32'h0);
  endtask

  task automatic t_ident();
    cfg_read_chk("R8 ident", 32'h0000_0000, W_IDENT);
    cfg_read_chk("R8 class", 32'h0000_0008, W_CLASS);
    cfg_read_chk("R1 cmd readback", 32'h0000_0004, {STATUS, 16'h0000});
  endtask

  task automatic t_cmd_write();
    cfg_write(32'h0000_0004, 32'hFFFF_0147, 4'b0000);
    check("R5 cmd full", {16'h0, cmd_reg}, 32'h0000_0147);
    cfg_read_chk("R5 cmd read", 32'h0000_0004, {STATUS, 16'h0147});
    cfg_write(32'h0000_0004, 32'h0000_3355, 4'b1110);
    check("R4 cmd lane0", {16'h0, cmd_reg}, 32'h0000_0155);
  endtask

  task automatic t_bar();
    cfg_write(32'h0000_0010, 32'hFFFF_FFFF, 4'b0000);
    check("R6 bar size", bar0, 32'hFFFF_F000);
    cfg_write(32'h0000_0010, 32'h1234_5678, 4'b0111);
    check("R4 bar lane3", bar0, 32'h12FF_F000);
    cfg_read_chk("R6 bar read", 32'h0000_0010, 32'h12FF_F000);
  endtask

  task automatic t_irq();
    cfg_write(32'h0000_003C, 32'hFFFF_FF5A, 4'b0000);
    check("R7 intline", {24'h0, int_line}, 32'h0000_005A);
    cfg_read_chk("R7 irq read", 32'h0000_003C, {W_IRQHI, 8'h5A});
  endtask

  task automatic t_handshake();
    addr_cycle(4'b1011, 32'h0000_0004);
    data_beat(32'h0000_FFFF, 4'b0000, 1'b0, 1'b1);
    check("R3 trdy high", {16'h0, cmd_reg}, 32'h0000_0155);
    data_beat(32'h0000_FFFF, 4'b0000, 1'b1, 1'b0);
    check("R3 irdy high", {16'h0, cmd_reg}, 32'h0000_0155);
    data_beat(32'h0000_0002, 4'b0000, 1'b0, 1'b0);
    check("R3 both low", {16'h0, cmd_reg}, 32'h0000_0002);
  endtask

  task automatic t_foreign_cmd();
    addr_cycle(4'b0111, 32'h0000_0004);
    data_beat(32'h0000_AAAA, 4'b0000, 1'b0, 1'b0);
    check("R2 memwr ignored", {16'h0, cmd_reg}, 32'h0000_0002);
    addr_cycle(4'b0110, 32'h0000_0000);
    check("R2 memrd zero", rd_data, 32'h0);
    addr_cycle(4'b1010, 32'h0000_003C);
    data_beat(32'h0000_0011, 4'b0000, 1'b0, 1'b0);
    check("R2 cfgrd no write", {24'h0, int_line}, 32'h0000_005A);
  endtask

  task automatic t_discard();
    cfg_write(32'h0000_0000, 32'hDEAD_BEEF, 4'b0000);
    cfg_write(32'h0000_0008, 32'hDEAD_BEEF, 4'b0000);
    cfg_write(32'h0000_0044, 32'hDEAD_BEEF, 4'b0000);
    check("R9 cmd kept", {16'h0, cmd_reg}, 32'h0000_0002);
    check("R9 bar kept", bar0, 32'h12FF_F000);
    check("R9 intline kept", {24'h0, int_line}, 32'h0000_005A);
    cfg_read_chk("R9 ident kept", 32'h0000_0000, W_IDENT);
    cfg_read_chk("R9 rd 80h", 32'h0000_0080, 32'h0);
    cfg_read_chk("R9 rd 0Ch", 32'h0000_000C, 32'h0);
  endtask

  task automatic t_addr_bits();
    cfg_write(32'hABCD_EF04, 32'h0000_0107, 4'b0000);
    check("R10 high bits ignored", {16'h0, cmd_reg}, 32'h0000_0107);
    cfg_write(32'h0000_0005, 32'h0000_0000, 4'b0000);
    check("R10 low bits exact", {16'h0, cmd_reg}, 32'h0000_0107);
    cfg_read_chk("R10 rd 11h", 32'h0000_0011, 32'h0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    rst_n = 1'b0; addr_phase = 1'b0; addr = '0; cbe_n = 4'hF;
    irdy_n = 1'b1; trdy_n = 1'b1; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_cmd_write();
    t_bar();
    t_irq();
    t_handshake();
    t_foreign_cmd();
    t_discard();
    t_addr_bits();
    report();
  end

endmodule